// File: doc/BRIEF.md
# I2C EEPROM Slave Controller

This block is a synthesizable two-wire bus slave that sits in front of a small byte array built from registers. It follows the usual serial EEPROM protocol. It watches oversampled SCL and SDA for START and STOP and matches a 7-bit device address. It accepts a word address and then either collects data bytes for a page write or shifts data out from an internal pointer. It pulls SDA low only through an open-drain enable, and it never stretches the clock.

Writes collect in a page buffer and reach the array only at the closing STOP. The controller then holds off further traffic for a fixed number of clock cycles, the way a real cell would while it programs. When a write-protect input is high, the device address and the word address are still acknowledged, but data is refused. One address pointer serves both reads and writes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A device byte is acknowledged only if bits 7..4 equal 4'b1010, bit 3 equals strapIn[2] and bit 2 equals strapIn[1]. With the default 512-byte array, bit 1 is not compared and supplies word-address bit 8. A mismatch leaves SDA released on the ninth clock.
- R2: After an acknowledged device byte with R/W (bit 0) = 0, the word address byte and every data byte are acknowledged. The bytes are stored from that address.
- R3: During a write, the low 4 address bits step and wrap inside the 16-byte page while the upper bits stay fixed. Bytes beyond the sixteenth replace the earlier entries for the same positions.
- R4: The array changes only at a STOP that follows at least one acknowledged data byte. A repeated START discards the buffered bytes.
- R5: With wpIn high, the device and word address bytes are acknowledged, the first data byte is not acknowledged, and the array and busy state stay unchanged.
- R6: After a committed write, every device byte is refused for BUSY_CYCLES clock cycles. After that, device bytes are acknowledged again.
- R7: A single pointer holds the last accessed address plus one, after both reads and writes. A read with R/W = 1 returns the byte at the pointer, and the pointer wraps from the last address to 0.
- R8: Read data leaves MSB first, and each bit changes only while SCL is low. The slave releases SDA for the master's acknowledge bit. A master ACK continues with the next byte, and a NACK ends the transfer.
- R9: After reset, sdaOe is low, the pointer is 0 and every array byte reads 8'hFF.
- R10: A START in the middle of a byte restarts the bit count, and the next 8 bits are taken as a device byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| strapIn | input | 3 | Device-address straps (bit 2 at address bit 3) |
| wpIn | input | 1 | Write protect; high refuses data bytes |
| sdaOe | output | 1 | When high, the pad pulls SDA low |

## Verification
Most internal faults here surface on the ninth clock of the next byte, as a missing or unexpected acknowledge. A wrong address match, busy count or protect decision all show up there. A corrupted pointer, page index or commit mask stays hidden until a later read, so every write scenario ends with read-back of the affected and neighbouring addresses, including the page wrap and array wrap. Faults in the read shifter appear as wrong bits within the same byte, or as SDA still held low during the master's acknowledge slot.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Control-to-datapath strobes, each one cycle wide
  typedef struct packed {
    logic setAddr;   // word address byte accepted
    logic putByte;   // data byte accepted into the page buffer
    logic takeByte;  // read byte loaded into the shifter
    logic commit;    // STOP after accepted data
    logic drop;      // START: abandon buffered data
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    K_DEV, K_WORD, K_DATA
  } byteKind_t;

endpackage

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  input  logic       wpIn,
  input  logic       busy,
  input  logic [7:0] rdData,
  output dpStrobe_t  stb,
  output logic [7:0] byteOut,
  output logic [2:0] devHi,
  output logic       sdaOe
);

  localparam int HI_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startC, stopC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startC  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopC   = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t  state;
  byteKind_t  kind;
  logic [3:0] cnt;
  logic [7:0] shiftR, txR;
  logic       rwBit, masterAck, anyData;
  logic [2:0] devHiR;

  // address match: strap positions below HI_BITS carry word-address bits
  logic strapMiss, accept;
  always_comb begin
    strapMiss = 1'b0;
    for (int i = 0; i < 3; i++)
      strapMiss = strapMiss | ((i >= HI_BITS) & (shiftR[i+1] ^ strapIn[i]));
    case (kind)
      K_DEV:   accept = (shiftR[7:4] == 4'b1010) && !strapMiss && !busy;
      K_WORD:  accept = 1'b1;
      default: accept = !wpIn;
    endcase
  end

  assign byteOut = shiftR;
  assign devHi   = devHiR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kind      <= K_DEV;
      cnt       <= '0;
      shiftR    <= '0;
      txR       <= '0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
      anyData   <= 1'b0;
      devHiR    <= '0;
      sdaOe     <= 1'b0;
      stb       <= '0;
    end else begin
      stb <= '0;
      if (startC) begin
        state    <= S_RX;
        kind     <= K_DEV;
        cnt      <= '0;
        sdaOe    <= 1'b0;
        anyData  <= 1'b0;
        stb.drop <= 1'b1;
      end else if (stopC) begin
        stb.commit <= anyData;
        anyData    <= 1'b0;
        state      <= S_IDLE;
        sdaOe      <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise && cnt != 4'd8) begin
              shiftR <= {shiftR[6:0], sdaS};
              cnt    <= cnt + 4'd1;
            end else if (sclFall && cnt == 4'd8) begin
              if (accept) begin
                sdaOe <= 1'b1;
                state <= S_RXACK;
                case (kind)
                  K_DEV: begin
                    rwBit  <= shiftR[0];
                    devHiR <= shiftR[3:1];
                  end
                  K_WORD:  stb.setAddr <= 1'b1;
                  default: begin
                    stb.putByte <= 1'b1;
                    anyData     <= 1'b1;
                  end
                endcase
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_RXACK: begin
            if (sclFall) begin
              cnt <= '0;
              if (kind == K_DEV && rwBit) begin
                txR          <= rdData;
                sdaOe        <= ~rdData[7];
                stb.takeByte <= 1'b1;
                state        <= S_TX;
              end else begin
                sdaOe <= 1'b0;
                state <= S_RX;
                kind  <= (kind == K_DEV) ? K_WORD : K_DATA;
              end
            end
          end
          S_TX: begin
            if (sclRise) begin
              cnt <= cnt + 4'd1;
            end else if (sclFall) begin
              if (cnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= S_TXACK;
              end else begin
                txR   <= {txR[6:0], 1'b0};
                sdaOe <= ~txR[6];
              end
            end
          end
          S_TXACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              cnt <= '0;
              if (masterAck) begin
                txR          <= rdData;
                sdaOe        <= ~rdData[7];
                stb.takeByte <= 1'b1;
                state        <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RXACK && kind == K_DEV) |-> !busy);

  // R5
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.putByte |-> !$past(wpIn));

  // R8
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe));

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] byteIn,
  input  logic [2:0] devHi,
  output logic [7:0] rdData,
  output logic       busy
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            memArr  [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_W-1:0]     ptr;
  logic [BUSY_W-1:0]     busyCnt;

  // pointer and page-valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      pageValid <= '0;
    end else begin
      if (stb.setAddr) begin
        ptr       <= ADDR_W'({devHi, byteIn});
        pageValid <= '0;
      end else if (stb.putByte) begin
        pageValid[ptr[PG_W-1:0]] <= 1'b1;
        ptr[PG_W-1:0]            <= ptr[PG_W-1:0] + 1'b1;
      end else if (stb.takeByte) begin
        ptr <= ptr + 1'b1;
      end else if (stb.commit || stb.drop) begin
        pageValid <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.putByte) pageBuf[ptr[PG_W-1:0]] <= byteIn;
  end

  // array: committed page entries land at the page the pointer sits in
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= 8'hFF;
    end else if (stb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageValid[i])
          memArr[{ptr[ADDR_W-1:PG_W], PG_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCnt <= '0;
    else if (stb.commit)      busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busyCnt != '0)   busyCnt <= busyCnt - 1'b1;
  end

  assign busy   = (busyCnt != '0);
  assign rdData = memArr[ptr];

  // R4
  commit_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (pageValid != '0));

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.putByte |=> $stable(ptr[ADDR_W-1:PG_W]));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> busy);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  input  logic       wpIn,
  output logic       sdaOe
);

  localparam int ADDR_W = $clog2(MEM_BYTES);

  dpStrobe_t  stb;
  logic [7:0] byteBus, rdData;
  logic [2:0] devHi;
  logic       busy;

  i2c_slave_ctrl #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strapIn (strapIn),
    .wpIn    (wpIn),
    .busy    (busy),
    .rdData  (rdData),
    .stb     (stb),
    .byteOut (byteBus),
    .devHi   (devHi),
    .sdaOe   (sdaOe)
  );

  eeprom_datapath #(
    .MEM_BYTES   (MEM_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .byteIn (byteBus),
    .devHi  (devHi),
    .rdData (rdData),
    .busy   (busy)
  );

endmodule

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;

  localparam int BUSY = 1000;
  localparam int H    = 20;  // clocks per SCL half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, wpIn = 1'b0;
  logic [2:0] strapIn = 3'b010;
  logic sdaOe, sdaLine;

  int checks = 0, fails = 0;
  logic [7:0] rdBuf [0:31];

  always #2.5 clk = ~clk;

  assign sdaLine = sdaOe ? 1'b0 : mSda;

  i2c_eeprom_slave #(.BUSY_CYCLES(BUSY)) i_i2c_eeprom_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .strapIn(strapIn), .wpIn(wpIn), .sdaOe(sdaOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart;
    mScl = 1'b0; tick(H/2);
    mSda = 1'b1; tick(H/2);
    mScl = 1'b1; tick(H/2);
    mSda = 1'b0; tick(H/2);
    mScl = 1'b0; tick(H/2);
  endtask

  task automatic busStop;
    mScl = 1'b0; tick(H/2);
    mSda = 1'b0; tick(H/2);
    mScl = 1'b1; tick(H/2);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(H/2);
      mScl = 1'b1; tick(H);
      mScl = 1'b0; tick(H/2);
    end
    mSda = 1'b1; tick(H/2);
    mScl = 1'b1; tick(H/2);
    acked = (sdaLine == 1'b0);
    tick(H/2);
    mScl = 1'b0; tick(H/2);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] d);
    mSda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(H/2); mScl = 1'b1;
      tick(H/2); d = {d[6:0], sdaLine};
      tick(H/2); mScl = 1'b0;
      tick(H/2);
    end
    mSda = giveAck ? 1'b0 : 1'b1;
    tick(H/2); mScl = 1'b1;
    tick(H/2);
    // R8: slave has let go of SDA for the acknowledge slot
    check(sdaLine == mSda, "R8 release", sdaLine, mSda);
    tick(H/2); mScl = 1'b0;
    tick(H/2); mSda = 1'b1;
  endtask

  task automatic writeSeq(input logic [7:0] dev, input logic [7:0] word, input int n,
                          input logic [7:0] base, input bit waitDone, input string req);
    bit a;
    busStart;
    sendByte(dev, a);  check(a, req, a, 1);
    sendByte(word, a); check(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(base + 8'(i), a);
      check(a, req, a, 1);
    end
    busStop;
    if (waitDone) tick(BUSY + 100);
  endtask

  task automatic readAt(input logic [7:0] dev, input logic [7:0] word, input int n);
    bit a;
    busStart;
    sendByte(dev, a);  check(a, "R2 dummy dev", a, 1);
    sendByte(word, a); check(a, "R2 dummy word", a, 1);
    busStart;
    sendByte(dev | 8'h01, a); check(a, "R7 read dev", a, 1);
    for (int i = 0; i < n; i++) readByte(i != n - 1, rdBuf[i]);
    busStop;
  endtask

  task automatic curRead(input logic [7:0] dev, output logic [7:0] d);
    bit a;
    busStart;
    sendByte(dev | 8'h01, a); check(a, "R7 cur dev", a, 1);
    readByte(1'b0, d);
    busStop;
  endtask

  task automatic tReset;
    logic [7:0] d;
    check(sdaOe == 1'b0, "R9 sdaOe", sdaOe, 0);
    curRead(8'hA4, d);
    check(d == 8'hFF, "R9 erased", d, 8'hFF);
  endtask

  task automatic tByteWrite;
    logic [7:0] d;
    writeSeq(8'hA6, 8'h05, 2, 8'h3C, 1'b1, "R2 ack");
    readAt(8'hA6, 8'h05, 1);
    check(rdBuf[0] == 8'h3C, "R2 data", rdBuf[0], 8'h3C);
    curRead(8'hA4, d);
    check(d == 8'h3D, "R7 after read", d, 8'h3D);
    writeSeq(8'hA6, 8'h04, 1, 8'h99, 1'b1, "R2 ack");
    curRead(8'hA4, d);
    check(d == 8'h3C, "R7 after write", d, 8'h3C);
    readAt(8'hA4, 8'h05, 1);
    check(rdBuf[0] == 8'hFF, "R1 bit8 select", rdBuf[0], 8'hFF);
  endtask

  task automatic tAddrMatch;
    bit a;
    busStart; sendByte(8'hAC, a); busStop;
    check(!a, "R1 A2 mismatch", a, 0);
    busStart; sendByte(8'hA0, a); busStop;
    check(!a, "R1 A1 mismatch", a, 0);
    busStart; sendByte(8'hB4, a); busStop;
    check(!a, "R1 prefix mismatch", a, 0);
  endtask

  task automatic tPage;
    writeSeq(8'hA4, 8'h2E, 4, 8'h11, 1'b1, "R3 ack");
    readAt(8'hA4, 8'h2E, 3);
    check(rdBuf[0] == 8'h11, "R3 2E", rdBuf[0], 8'h11);
    check(rdBuf[1] == 8'h12, "R3 2F", rdBuf[1], 8'h12);
    check(rdBuf[2] == 8'hFF, "R3 30 untouched", rdBuf[2], 8'hFF);
    readAt(8'hA4, 8'h20, 2);
    check(rdBuf[0] == 8'h13, "R3 wrap 20", rdBuf[0], 8'h13);
    check(rdBuf[1] == 8'h14, "R8 seq 21", rdBuf[1], 8'h14);
    writeSeq(8'hA4, 8'h40, 18, 8'h80, 1'b1, "R3 ack");
    readAt(8'hA4, 8'h40, 3);
    check(rdBuf[0] == 8'h90, "R3 overwrite 40", rdBuf[0], 8'h90);
    check(rdBuf[1] == 8'h91, "R3 overwrite 41", rdBuf[1], 8'h91);
    check(rdBuf[2] == 8'h82, "R3 keep 42", rdBuf[2], 8'h82);
  endtask

  task automatic tBusy;
    bit a;
    writeSeq(8'hA4, 8'h70, 1, 8'h55, 1'b0, "R6 ack");
    busStart; sendByte(8'hA4, a); busStop;
    check(!a, "R6 busy nack", a, 0);
    tick(BUSY + 100);
    busStart; sendByte(8'hA4, a); busStop;
    check(a, "R6 busy over", a, 1);
  endtask

  task automatic tWp;
    bit a;
    wpIn = 1'b1;
    busStart;
    sendByte(8'hA4, a); check(a, "R5 dev ack", a, 1);
    sendByte(8'h70, a); check(a, "R5 word ack", a, 1);
    sendByte(8'h00, a); check(!a, "R5 data nack", a, 0);
    busStop;
    busStart; sendByte(8'hA4, a); busStop;
    check(a, "R5 no busy", a, 1);
    wpIn = 1'b0;
    readAt(8'hA4, 8'h70, 1);
    check(rdBuf[0] == 8'h55, "R5 unchanged", rdBuf[0], 8'h55);
  endtask

  task automatic tAbort;
    bit a;
    logic [7:0] d;
    busStart;
    sendByte(8'hA4, a);
    sendByte(8'h60, a);
    sendByte(8'h77, a); check(a, "R4 data ack", a, 1);
    busStart;
    sendByte(8'hA5, a); check(a, "R4 restart dev", a, 1);
    readByte(1'b0, d);
    busStop;
    check(d == 8'hFF, "R4 ptr 61", d, 8'hFF);
    readAt(8'hA4, 8'h60, 1);
    check(rdBuf[0] == 8'hFF, "R4 no commit", rdBuf[0], 8'hFF);
  endtask

  task automatic tStartMid;
    bit a;
    busStart;
    mSda = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(H/2); mScl = 1'b1; tick(H); mScl = 1'b0; tick(H/2);
    end
    busStart;
    sendByte(8'hA4, a);
    busStop;
    check(a, "R10 restart count", a, 1);
  endtask

  task automatic tWrap;
    logic [7:0] d;
    writeSeq(8'hA4, 8'h00, 1, 8'hC3, 1'b1, "R7 ack");
    writeSeq(8'hA6, 8'hFF, 1, 8'h5A, 1'b1, "R7 ack");
    readAt(8'hA6, 8'hFF, 1);
    check(rdBuf[0] == 8'h5A, "R7 last addr", rdBuf[0], 8'h5A);
    curRead(8'hA4, d);
    check(d == 8'hC3, "R7 wrap to 0", d, 8'hC3);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    tReset;
    tByteWrite;
    tAddrMatch;
    tPage;
    tBusy;
    tWp;
    tAbort;
    tStartMid;
    tWrap;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule